// File: doc/BRIEF.md
# Time-Slot Stepper Phase Sequencer

This block drives the four phase lines of a scanner's stepper motor. It has no step table of its own. Software programs a target slot number and a pending four-bit phase pattern. A 16-bit slot counter advances by one on each tick pulse while the block is enabled. On the tick that brings the counter to the programmed slot, the pending pattern is copied onto the phase outputs and an interrupt is raised. Software then queues the next slot and pattern. The order and spacing of the patterns that software supplies set the motor's direction and speed.

The interrupt stays high until software acknowledges it through a register write. If a second slot match arrives while the interrupt is still pending, a sticky overrun flag is set. Pulling the enable input low forces all phase lines low and holds the counter at zero. Counting restarts from zero once the block is enabled again. The register port is a plain single-cycle write strobe with no back-pressure: a write is accepted in every cycle in which `wr_en` is high.

Top module: `step_seq_top`

## Requirements
- R1: After reset, `phase` is 0, `irq` is 0, `overrun` is 0, the slot counter is 0, the target slot is 0 and the pending pattern is 0.
- R2: While `enable` is high, each cycle with `tick` high advances the 16-bit slot counter by one. The counter wraps from 65535 to 0. A match fires on the tick that makes the new counter value equal the target slot.
- R3: On a match, `phase` takes the pending pattern and `irq` goes high. Both are visible from the clock edge that applies the matching tick.
- R4: A write to register 1 (`wr_addr`=1) stores `wr_data[3:0]` as the pending pattern. It leaves `phase` unchanged until the next match. `phase` changes only on a match or when the block is disabled.
- R5: `irq` stays high until a write to register 2 with `wr_data[0]`=1. A write to register 2 with `wr_data[0]`=0 leaves `irq` unchanged.
- R6: A match while `irq` is already high sets `overrun`. `overrun` stays set until a write to register 2 with `wr_data[1]`=1.
- R7: While `enable` is low, `phase` is 0 from the next edge on, ticks are ignored, no match fires, and the counter is held at 0. Register writes are still accepted.
- R8: A write to register 0 stores `wr_data[15:0]` as the target slot, and it applies to the ticks that follow. When a match and an acknowledge write fall in the same cycle, the match wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the sequencer. When low, phases are low and the counter is cleared |
| tick | input | 1 | Slot tick pulse, one count per cycle high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 target slot, 1 pending pattern, 2 acknowledge |
| wr_data | input | 16 | Write data |
| phase | output | 4 | Stepper phase outputs |
| irq | output | 1 | Slot-match interrupt, sticky |
| overrun | output | 1 | Match arrived while the interrupt was pending, sticky |

## Verification
The sequencer is driven with ticks on every cycle and with ticks spaced by idle cycles. Both patterns must fire the match on the same count, which separates counting by ticks from counting by clock cycles. Pattern writes are issued without ticks to show that the outputs stay buffered. Matches are let through with the interrupt left pending, to show overrun, and are placed in the same cycle as an acknowledge, to show which side takes priority. A disable and re-enable sequence, followed by a run of 65,535 consecutive ticks, checks that the counter restarts from zero and that it wraps at 16 bits.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

  // register select on the write port
  typedef enum logic [1:0] {
    REG_SLOT    = 2'd0,
    REG_PATTERN = 2'd1,
    REG_ACK     = 2'd2,
    REG_SPARE   = 2'd3
  } reg_sel_e;

  // acknowledge-register bit positions
  localparam int ACK_IRQ_BIT = 0;
  localparam int ACK_OVR_BIT = 1;

endpackage

// File: rtl/step_seq_regs.sv
module step_seq_regs
  import step_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PH_W   = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  target,
  output logic [PH_W-1:0]   pattern,
  output logic              ack_irq,
  output logic              ack_ovr
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target  <= '0;
      pattern <= '0;
    end else if (wr_en) begin
      if (sel == REG_SLOT)    target  <= wr_data[CNT_W-1:0];
      if (sel == REG_PATTERN) pattern <= wr_data[PH_W-1:0];
    end
  end

  always_comb begin
    ack_irq = wr_en && (sel == REG_ACK) && wr_data[ACK_IRQ_BIT];
    ack_ovr = wr_en && (sel == REG_ACK) && wr_data[ACK_OVR_BIT];
  end

endmodule

// File: rtl/step_seq_slot_cnt.sv
module step_seq_slot_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic [CNT_W-1:0] target,
  output logic             match
);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] count_nxt;
  logic             step;

  assign step      = enable && tick;
  assign count_nxt = count + 1'b1;
  assign match     = step && (count_nxt == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (!enable) count <= '0;
    else if (step)    count <= count_nxt;
  end

endmodule

// File: rtl/step_seq_event.sv
module step_seq_event (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic ack_irq,
  input  logic ack_ovr,
  output logic irq,
  output logic overrun
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (match)        irq <= 1'b1;
      else if (ack_irq) irq <= 1'b0;
      if (match && irq) overrun <= 1'b1;
      else if (ack_ovr) overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/step_seq_phase_out.sv
module step_seq_phase_out #(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            match,
  input  logic [PH_W-1:0] pattern,
  output logic [PH_W-1:0] phase
);

  for (genvar i = 0; i < PH_W; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase[i] <= 1'b0;
      else if (!enable) phase[i] <= 1'b0;
      else if (match)   phase[i] <= pattern[i];
    end
  end

endmodule

// File: rtl/step_seq_top.sv
module step_seq_top #(
  parameter int CNT_W  = 16,
  parameter int PH_W   = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PH_W-1:0]   phase,
  output logic              irq,
  output logic              overrun
);

  logic [CNT_W-1:0] target;
  logic [PH_W-1:0]  pattern;
  logic             ack_irq;
  logic             ack_ovr;
  logic             match;

  step_seq_regs #(.CNT_W(CNT_W), .PH_W(PH_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .target(target), .pattern(pattern),
    .ack_irq(ack_irq), .ack_ovr(ack_ovr)
  );

  step_seq_slot_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .target(target), .match(match)
  );

  step_seq_event u_evt (
    .clk(clk), .rst_n(rst_n), .match(match), .ack_irq(ack_irq),
    .ack_ovr(ack_ovr), .irq(irq), .overrun(overrun)
  );

  step_seq_phase_out #(.PH_W(PH_W)) u_out (
    .clk(clk), .rst_n(rst_n), .enable(enable), .match(match),
    .pattern(pattern), .phase(phase)
  );

endmodule

// File: rtl/step_seq_checker.sv
module step_seq_checker #(
  parameter int PH_W   = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              tick,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [PH_W-1:0]   phase,
  input logic              irq,
  input logic              overrun
);

  logic ack0;
  logic step;
  assign ack0 = wr_en && (wr_addr == 2'd2) && wr_data[0];
  assign step = enable && tick;

  AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase == '0)); // R7

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> $stable(phase)); // R4

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(step)); // R3

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack0) |=> irq); // R5

  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack0 && !step) |=> !irq); // R5

  AST_OVR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(irq) && $past(step))); // R6

endmodule

bind step_seq_top step_seq_checker #(.PH_W(PH_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .phase(phase), .irq(irq),
  .overrun(overrun)
);

// File: tb/step_seq_top_bench.sv
`timescale 1ns/1ps
module step_seq_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [3:0]  phase;
  logic        irq;
  logic        overrun;

  int total = 0;
  int bad = 0;
  bit live = 1'b0;

  always #5 clk = ~clk;

  step_seq_top u_step_seq_top (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .phase(phase), .irq(irq),
    .overrun(overrun)
  );

  // behavioural reference
  int m_cnt, m_tgt, m_pend, m_phase, m_irq, m_ovr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_tgt = 0; m_pend = 0; m_phase = 0; m_irq = 0; m_ovr = 0;
    end else begin
      int hit, a0, a1, nxt;
      nxt = (m_cnt + 1) % 65536;
      hit = (enable && tick && nxt == m_tgt) ? 1 : 0;
      a0  = (wr_en && wr_addr == 2 && wr_data[0]) ? 1 : 0;
      a1  = (wr_en && wr_addr == 2 && wr_data[1]) ? 1 : 0;
      if (hit && m_irq) m_ovr = 1; else if (a1) m_ovr = 0;
      if (hit) m_irq = 1; else if (a0) m_irq = 0;
      if (!enable) m_phase = 0; else if (hit) m_phase = m_pend;
      if (!enable) m_cnt = 0; else if (tick) m_cnt = nxt;
      if (wr_en && wr_addr == 0) m_tgt = wr_data;
      if (wr_en && wr_addr == 1) m_pend = wr_data[3:0];
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // lockstep comparison each cycle
  always @(negedge clk) begin
    if (live) begin
      check("R3 phase vs model", phase, m_phase);
      check("R5 irq vs model", irq, m_irq);
      check("R6 overrun vs model", overrun, m_ovr);
    end
  end

  task automatic drive(bit t, bit w, logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    tick = t; wr_en = w; wr_addr = a; wr_data = d;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 2'd0, 16'd0);
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;
    idle();
    check("R1 reset phase", phase, 0);
    check("R1 reset irq", irq, 0);
    check("R1 reset overrun", overrun, 0);

    // R3: dense ticks, target 5, pattern 3
    enable = 1'b1;
    drive(0, 1, 2'd0, 16'd5);
    drive(0, 1, 2'd1, 16'd3);
    for (int i = 0; i < 4; i++) drive(1, 0, 2'd0, 16'd0);
    idle();
    check("R3 no match before slot", irq, 0);
    check("R3 phase held before slot", phase, 0);
    drive(1, 0, 2'd0, 16'd0);
    idle();
    check("R3 phase loaded on match", phase, 3);
    check("R3 irq raised on match", irq, 1);

    // R4: pattern write is buffered
    drive(0, 1, 2'd1, 16'd6);
    idle();
    check("R4 phase unchanged after pattern write", phase, 3);

    // R5: acknowledge semantics
    drive(0, 1, 2'd2, 16'd2);
    idle();
    check("R5 irq kept when bit0 clear", irq, 1);
    drive(0, 1, 2'd2, 16'd1);
    idle();
    check("R5 irq cleared by ack", irq, 0);

    // R8 / R2: sparse ticks to new target 7
    drive(0, 1, 2'd0, 16'd7);
    drive(1, 0, 2'd0, 16'd0);
    idle();
    idle();
    check("R2 one sparse tick no match", irq, 0);
    drive(1, 0, 2'd0, 16'd0);
    idle();
    check("R8 new target matched", irq, 1);
    check("R8 phase from pending", phase, 6);

    // R6: match while irq pending
    drive(0, 1, 2'd0, 16'd9);
    drive(0, 1, 2'd1, 16'd9);
    drive(1, 0, 2'd0, 16'd0);
    drive(1, 0, 2'd0, 16'd0);
    idle();
    check("R6 overrun set", overrun, 1);
    check("R6 phase still updates", phase, 9);
    drive(0, 1, 2'd2, 16'd2);
    idle();
    check("R6 overrun cleared", overrun, 0);
    check("R6 irq untouched by ovr ack", irq, 1);

    // R8: match and ack in same cycle
    drive(0, 1, 2'd0, 16'd10);
    drive(1, 1, 2'd2, 16'd1);
    idle();
    check("R8 match beats ack", irq, 1);
    drive(0, 1, 2'd2, 16'd3);
    idle();
    check("R5 both flags cleared", irq + overrun, 0);

    // R7: disable
    enable = 1'b0;
    idle();
    check("R7 phase low when disabled", phase, 0);
    drive(0, 1, 2'd0, 16'd2);
    drive(0, 1, 2'd1, 16'd5);
    for (int i = 0; i < 3; i++) drive(1, 0, 2'd0, 16'd0);
    idle();
    check("R7 ticks ignored while disabled", irq, 0);
    enable = 1'b1;
    drive(1, 0, 2'd0, 16'd0);
    drive(1, 0, 2'd0, 16'd0);
    idle();
    check("R7 counter restarted from zero", irq, 1);
    check("R7 phase after re-enable", phase, 5);

    // R2: wrap at 16 bits (counter now 2)
    drive(0, 1, 2'd2, 16'd1);
    drive(0, 1, 2'd0, 16'd1);
    drive(0, 1, 2'd1, 16'd12);
    for (int i = 0; i < 65534; i++) drive(1, 0, 2'd0, 16'd0);
    idle();
    check("R2 no match at wrap to zero", irq, 0);
    drive(1, 0, 2'd0, 16'd0);
    idle();
    check("R2 match after wrap", irq, 1);
    check("R2 phase after wrap", phase, 12);

    idle();
    live = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule